// File: doc/BRIEF.md
# Pixel Run Copy and Fill Engine

This block moves short horizontal runs of 8-bit pixels inside a framebuffer. A host talks to it through a small word-addressed command window. A write with address bit 2 clear only stores a colour word. A write with address bit 2 set starts an operation. The target pixel index comes from the write address. The source pixel index and the run length both come from the write data.

The engine has a simple dual-port synchronous RAM interface: one read port with one cycle of latency and one write port. It handles one pixel per cycle. In copy mode each pixel is read, then written one cycle later. In fill mode no reads are issued and every target pixel gets the low byte of the stored colour. `busy` is held while the run is in progress. `cmd_ready` is low during that time, so a new command waits at the window. A one-cycle `done` pulse marks the end of the run.

Top module: `pix_blitter`

## Requirements
- R1: While reset is asserted and right after it is released, `busy` and `done` are 0, `cmd_ready` is 1, and neither `mem_rd_en` nor `mem_wr_en` is active.
- R2: An accepted write with `cmd_addr[2]`=0 stores `cmd_wdata` as the colour word and starts nothing: `busy` stays 0 and no RAM strobe follows.
- R3: An accepted write with `cmd_addr[2]`=1 starts a run. Its first target pixel is `cmd_addr[22:3]`, a 20-bit index. Address bits above 22 and bits 1:0 have no effect.
- R4: The run length is `cmd_wdata[28:24]` + 1, so 1 to 32 pixels, and exactly that many RAM writes occur. `cmd_wdata[31:29]` have no effect.
- R5: When `cmd_wdata[23:0]` = 0xFFFFFF, the run is a fill. It issues no reads and writes the low byte of the stored colour word to consecutive increasing target indices, one per cycle.
- R6: Otherwise the run is a copy from source index `cmd_wdata[23:0]`. In the cycle after acceptance the read of the source index is issued. Source pixel k is read in run cycle k and written to target index + k in cycle k+1, with indices increasing.
- R7: Overlapping copies follow that schedule. A write becomes visible to reads from the next cycle on, and a read that hits the address being written in the same cycle returns the old value. So a target one above the source gives an exact shifted copy, and a target two or more above the source repeats the leading pixels.
- R8: While `busy` is 1, `cmd_ready` is 0 and a pending command of either kind is held off. It takes effect only after the run ends, and it leaves the run and the stored colour untouched until then.
- R9: `done` is a single-cycle pulse in the cycle after the last RAM write of a run. `busy` is already 0 in that cycle, and there is exactly one pulse per run.
- R10: An accepted read (`cmd_write`=0) returns `cmd_rdata` = 0 and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command window access request |
| cmd_ready | output | 1 | Access accepted on this edge when high |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | BUS_AW | Byte address in the window |
| cmd_wdata | input | 32 | Write data |
| cmd_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_rd_en | output | 1 | RAM read strobe |
| mem_rd_addr | output | MEM_AW | RAM read pixel index |
| mem_rd_data | input | PIX_W | RAM read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_wr_addr | output | MEM_AW | RAM write pixel index |
| mem_wr_data | output | PIX_W | RAM write data |

## Verification
In a copy run, the read of source pixel k and the write of target pixel k-1 share a cycle. When the target sits one index above the source, both hit the same RAM word in that cycle. Copies are run with a target exactly one above, two above and below the source. The whole RAM image is then compared with a bench model that replays the schedule: read first, with the earlier pixel's write landing only at the end of the cycle. A second collision is a new command that arrives in the cycles of a run. It is held with `cmd_ready` low, and the bench checks that it neither overlaps the run nor changes the colour used by the following fill.

// File: rtl/pix_blit_pkg.sv
package pix_blit_pkg;
  // field widths of the fixed command word
  localparam int DST_W  = 20;
  localparam int SRC_W  = 24;
  localparam int LFLD_W = 5;
  localparam int LEN_W  = LFLD_W + 1;
  localparam int DST_LSB = 3;
  localparam int GO_BIT  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_FILL = 2'd2
  } blit_state_e;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DST_W-1:0] dst;
    logic [LEN_W-1:0] len;
    logic             fill;
  } blit_cmd_t;
endpackage

// File: rtl/pix_blit_dec.sv
module pix_blit_dec
  import pix_blit_pkg::*;
#(
  parameter int BUS_AW = 24,
  parameter int DATA_W = 32
) (
  input  logic [BUS_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              go_word,
  output blit_cmd_t         cmd
);
  localparam int LEN_LSB = SRC_W;
  localparam int TOP_USED = DST_LSB + DST_W;

  always_comb begin
    go_word  = addr[GO_BIT];
    cmd.dst  = addr[DST_LSB +: DST_W];
    cmd.src  = wdata[SRC_W-1:0];
    cmd.len  = LEN_W'(wdata[LEN_LSB +: LFLD_W]) + LEN_W'(1);
    cmd.fill = &wdata[SRC_W-1:0];
  end

  logic unused_bits;
  generate
    if (BUS_AW > TOP_USED) begin : g_hi
      assign unused_bits = ^{addr[BUS_AW-1:TOP_USED], addr[1:0],
                             wdata[DATA_W-1:LEN_LSB+LFLD_W]};
    end else begin : g_nohi
      assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:LEN_LSB+LFLD_W]};
    end
  endgenerate
endmodule

// File: rtl/pix_blit_seq.sv
module pix_blit_seq
  import pix_blit_pkg::*;
#(
  parameter int MEM_AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  blit_cmd_t         cmd,
  output logic              busy,
  output logic              done,
  output logic              fill_mode,
  output logic              rd_en,
  output logic [MEM_AW-1:0] rd_addr,
  output logic              wr_en,
  output logic [MEM_AW-1:0] wr_addr
);
  blit_state_e       state_q, state_d;
  logic [LEN_W-1:0]  rd_left_q, rd_left_d;
  logic [LEN_W-1:0]  wr_left_q, wr_left_d;
  logic [MEM_AW-1:0] src_q, src_d;
  logic [MEM_AW-1:0] dst_q, dst_d;
  logic              pend_q, pend_d;
  logic              done_q, done_d;

  always_comb begin
    rd_en = (state_q == ST_COPY) && (rd_left_q != '0);
    wr_en = (state_q == ST_FILL) || ((state_q == ST_COPY) && pend_q);

    state_d   = state_q;
    rd_left_d = rd_left_q;
    wr_left_d = wr_left_q;
    src_d     = src_q;
    dst_d     = dst_q;
    pend_d    = rd_en;
    done_d    = 1'b0;

    if (state_q == ST_IDLE) begin
      if (go) begin
        state_d   = cmd.fill ? ST_FILL : ST_COPY;
        rd_left_d = cmd.fill ? '0 : cmd.len;
        wr_left_d = cmd.len;
        src_d     = MEM_AW'(cmd.src);
        dst_d     = MEM_AW'(cmd.dst);
      end
    end else begin
      if (rd_en) begin
        rd_left_d = rd_left_q - LEN_W'(1);
        src_d     = src_q + MEM_AW'(1);
      end
      if (wr_en) begin
        wr_left_d = wr_left_q - LEN_W'(1);
        dst_d     = dst_q + MEM_AW'(1);
        if (wr_left_q == LEN_W'(1)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rd_left_q <= '0;
      wr_left_q <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      pend_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      rd_left_q <= rd_left_d;
      wr_left_q <= wr_left_d;
      src_q     <= src_d;
      dst_q     <= dst_d;
      pend_q    <= pend_d;
      done_q    <= done_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign fill_mode = (state_q == ST_FILL);
  assign rd_addr   = src_q;
  assign wr_addr   = dst_q;
endmodule

// File: rtl/pix_blit_dp.sv
module pix_blit_dp #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_en,
  input  logic [PIX_W-1:0] colour_in,
  input  logic             sel_fill,
  input  logic [PIX_W-1:0] rd_data,
  output logic [PIX_W-1:0] wr_data
);
  logic [PIX_W-1:0] colour_q, colour_d;

  always_comb begin
    colour_d = colour_q;
    if (latch_en) colour_d = colour_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) colour_q <= '0;
    else        colour_q <= colour_d;
  end

  assign wr_data = sel_fill ? colour_q : rd_data;
endmodule

// File: rtl/pix_blitter.sv
module pix_blitter
  import pix_blit_pkg::*;
#(
  parameter int BUS_AW = 24,
  parameter int DATA_W = 32,
  parameter int MEM_AW = 24,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [BUS_AW-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] cmd_rdata,
  output logic              busy,
  output logic              done,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic [PIX_W-1:0]  mem_rd_data,
  output logic              mem_wr_en,
  output logic [MEM_AW-1:0] mem_wr_addr,
  output logic [PIX_W-1:0]  mem_wr_data
);
  blit_cmd_t dcmd;
  logic      go_word, wr_acc, go, latch_en, fill_mode;

  pix_blit_dec #(.BUS_AW(BUS_AW), .DATA_W(DATA_W)) u_dec (
    .addr(cmd_addr), .wdata(cmd_wdata), .go_word(go_word), .cmd(dcmd)
  );

  assign cmd_ready = ~busy;
  assign wr_acc    = cmd_valid & cmd_ready & cmd_write;
  assign go        = wr_acc & go_word;
  assign latch_en  = wr_acc & ~go_word;
  assign cmd_rdata = '0;

  pix_blit_seq #(.MEM_AW(MEM_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd(dcmd),
    .busy(busy), .done(done), .fill_mode(fill_mode),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr),
    .wr_en(mem_wr_en), .wr_addr(mem_wr_addr)
  );

  pix_blit_dp #(.PIX_W(PIX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en),
    .colour_in(cmd_wdata[PIX_W-1:0]), .sel_fill(fill_mode),
    .rd_data(mem_rd_data), .wr_data(mem_wr_data)
  );
endmodule

// File: rtl/pix_blitter_chk.sv
module pix_blitter_chk #(
  parameter int BUS_AW = 24,
  parameter int DATA_W = 32,
  parameter int MEM_AW = 24,
  parameter int PIX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [BUS_AW-1:0] cmd_addr,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [MEM_AW-1:0] mem_wr_addr
);
  assert_start_from_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_write && cmd_addr[2]));

  assert_colour_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_write && !cmd_addr[2]) |=> !busy);

  assert_read_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_write) |=> !busy);

  assert_write_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> busy);

  assert_read_then_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_wr_en);

  assert_write_steps_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && $past(mem_wr_en)) |-> (mem_wr_addr == MEM_AW'($past(mem_wr_addr) + 1'b1)));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_wr_en));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_wr_en));

  assert_ready_falls_with_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !cmd_ready);
endmodule

bind pix_blitter pix_blitter_chk #(
  .BUS_AW(BUS_AW), .DATA_W(DATA_W), .MEM_AW(MEM_AW), .PIX_W(PIX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_write(cmd_write), .cmd_addr(cmd_addr), .busy(busy), .done(done),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr)
);

// File: tb/pix_blitter_tb_top.sv
`timescale 1ns/1ps
module pix_blitter_tb_top;
  localparam int BUS_AW = 24;
  localparam int MEM_AW = 24;
  localparam int DEPTH  = 1024;

  typedef struct packed {
    logic [31:0] fillv;
    logic [23:0] baddr;
    logic [31:0] bdata;
    logic [5:0]  elen;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h000000A5, 24'h000324, 32'h07FFFFFF, 6'd8 },  // fill 8 @100
    '{32'h00000077, 24'h000644, 32'h1F00000A, 6'd32},  // copy 10->200 x32
    '{32'h00000077, 24'h00096C, 32'h0F00012C, 6'd16},  // copy 300->301 x16
    '{32'h00000077, 24'h000C94, 32'h09000190, 6'd10},  // copy 400->402 x10
    '{32'h00000077, 24'h00101C, 32'h0B000208, 6'd12},  // copy 520->515 x12
    '{32'h00000077, 24'h0015E4, 32'hE0000005, 6'd1 },  // copy 5->700 x1
    '{32'h123456C3, 24'h801C24, 32'hFFFFFFFF, 6'd32},  // fill 32 @900
    '{32'h00000077, 24'h000004, 32'h170003E8, 6'd24}   // copy 1000->0 x24
  };

  logic clk, rst_n;
  logic cmd_valid, cmd_ready, cmd_write;
  logic [BUS_AW-1:0] cmd_addr;
  logic [31:0] cmd_wdata, cmd_rdata;
  logic busy, done, mem_rd_en, mem_wr_en;
  logic [MEM_AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [7:0] mem_rd_data, mem_wr_data;

  pix_blitter dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // RAM model: read returns old contents when the same word is written
  logic [7:0] ram [DEPTH];
  logic [7:0] exp_m [DEPTH];
  logic ram_init;
  always @(posedge clk) begin
    if (ram_init) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= 8'(i * 37 + 11);
    end else begin
      if (mem_wr_en) ram[mem_wr_addr[9:0]] <= mem_wr_data;
      if (mem_rd_en) mem_rd_data <= ram[mem_rd_addr[9:0]];
    end
  end

  // port monitor, counters only grow
  int wr_cnt = 0, done_cnt = 0, busy_cyc = 0, stall_err = 0, done_busy_err = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr_en) wr_cnt++;
      if (busy) busy_cyc++;
      if (busy && cmd_ready) stall_err++;
      if (done) begin
        done_cnt++;
        if (busy) done_busy_err++;
      end
    end
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic model(input int src, input int dst, input int len,
                       input bit isfill, input logic [7:0] fv);
    bit havep = 0;
    int pa = 0;
    logic [7:0] pv = 8'h00, rv;
    if (isfill) begin
      for (int k = 0; k < len; k++) exp_m[dst + k] = fv;
    end else begin
      for (int k = 0; k < len; k++) begin
        rv = exp_m[src + k];
        if (havep) exp_m[pa] = pv;
        pa = dst + k; pv = rv; havep = 1;
      end
      exp_m[pa] = pv;
    end
  endtask

  function automatic int mismatches();
    int m = 0;
    for (int i = 0; i < DEPTH; i++) if (ram[i] !== exp_m[i]) m++;
    return m;
  endfunction

  task automatic run_vec(input vec_t v, input string req);
    int src, dst, len, w0, d0;
    bit isf;
    dst = int'((v.baddr >> 3) & 24'h0FFFFF);
    src = int'(v.bdata[23:0]);
    len = int'(v.bdata[28:24]) + 1;
    isf = (v.bdata[23:0] == 24'hFFFFFF);
    bus_write(v.baddr & ~24'h4, v.fillv);
    model(src, dst, len, isf, v.fillv[7:0]);
    w0 = wr_cnt; d0 = done_cnt;
    bus_write(v.baddr, v.bdata);
    wait_idle();
    chk(wr_cnt - w0 == int'(v.elen), "R4", "write count", wr_cnt - w0, v.elen);
    chk(done_cnt - d0 == 1, "R9", "done pulses", done_cnt - d0, 1);
    chk(mismatches() == 0, req, "ram mismatches", mismatches(), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0, b0, d0;
    rst_n = 1'b0; ram_init = 1'b1;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    for (int i = 0; i < DEPTH; i++) exp_m[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !done && cmd_ready && !mem_rd_en && !mem_wr_en, "R1",
        "reset outputs", {busy, done, cmd_ready, mem_rd_en, mem_wr_en}, 5'b00100);
    ram_init = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && cmd_ready && !mem_rd_en && !mem_wr_en, "R1",
        "after release", {busy, done, cmd_ready, mem_rd_en, mem_wr_en}, 5'b00100);

    // R2: colour write starts nothing
    w0 = wr_cnt; b0 = busy_cyc;
    bus_write(24'h000100, 32'hDEADBEEE);
    repeat (4) @(negedge clk);
    chk(wr_cnt == w0 && busy_cyc == b0, "R2", "activity after colour write",
        (wr_cnt - w0) + (busy_cyc - b0), 0);

    // R10: read returns zero and starts nothing
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 24'h000194; cmd_wdata = 32'h05FFFFFF;
    #1;
    chk(cmd_rdata == 32'h0, "R10", "read data", cmd_rdata, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_cnt == w0 && busy_cyc == b0, "R10", "activity after read",
        (wr_cnt - w0) + (busy_cyc - b0), 0);

    // table walk: R3, R5, R6, R7
    for (int n = 0; n < NVEC; n++) begin
      run_vec(VECS[n], (VECS[n].bdata[23:0] == 24'hFFFFFF) ? "R5" :
                       (n >= 2 && n <= 4) ? "R7" : (n == 6 ? "R3" : "R6"));
    end

    // R6: cycle timing of first read and first write
    bus_write(24'h000004 | (24'd600 << 3), 32'h03000014);
    chk(mem_rd_en && mem_rd_addr == 24'd20 && !mem_wr_en, "R6", "first read",
        mem_rd_addr, 20);
    @(negedge clk);
    chk(mem_wr_en && mem_wr_addr == 24'd600, "R6", "first write", mem_wr_addr, 600);
    model(20, 600, 4, 0, 8'h00);
    wait_idle();
    chk(mismatches() == 0, "R6", "timed copy", mismatches(), 0);

    // R8: colour write held off while a run is in progress
    bus_write(24'h000000, 32'h000000E1);
    d0 = done_cnt;
    bus_write(24'h000004 | (24'd750 << 3), 32'h1300001E);
    model(30, 750, 20, 0, 8'h00);
    bus_write(24'h000000, 32'h0000005A);
    chk(!busy && done_cnt - d0 == 1, "R8", "held write ended after run",
        done_cnt - d0, 1);
    chk(stall_err == 0, "R8", "ready high while busy", stall_err, 0);
    bus_write(24'h000004 | (24'd800 << 3), 32'h04FFFFFF);
    model(0, 800, 5, 1, 8'h5A);
    wait_idle();
    chk(mismatches() == 0, "R8", "copy and later fill", mismatches(), 0);
    chk(done_busy_err == 0, "R9", "done with busy", done_busy_err, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule